// File: doc/BRIEF.md
# Flag-Delimited Message Locator

This block locates and plays out one message from an external byte-wide memory. The memory holds messages back to back. Every message is closed by a terminator made of six consecutive bytes of value 0xAA. No directory or pointer table exists. To find message N, the block walks memory from address zero and counts terminators.

A start request carries the message number N. In the scan phase the block presents one address per clock. It feeds the returned bytes to a terminator detector and counts the terminators it finds. Once N-1 terminators have been seen, it pulses `found_o` and reports the following address as the message base.

It then switches to playback, where a slower consumer paces the reads with a step strobe. Each accepted step reads the current byte and advances the address. Audio bytes reach the decoder through a short hold-back line, so that terminator bytes are never passed on as audio. The step that completes the next terminator ends the message with a `done_o` pulse.

The memory is assumed to be synchronous: read data is valid one clock after the address is presented.

Top module: `msg_locator`

## Requirements
- R1: After reset the block is idle. `busy_o`, `found_o`, `done_o` and `audio_vld_o` are low, and `mem_addr_o` is zero.
- R2: A terminator is exactly six consecutive 0xAA bytes (binary 10101010). Any other byte clears the run. A run of fewer than six 0xAA bytes followed by another byte is ordinary message data.
- R3: A start request with N of 2 or more scans from address 0, one address per clock. The byte at address j is examined j+2 clocks after the clock that samples the start. When the (N-1)th terminator ends at address A, `found_o` pulses in the clock after that examination, and `msg_base_o` then equals A+1.
- R4: A start request with N equal to 1 skips the scan. `found_o` pulses in the clock right after the start is sampled, and `msg_base_o` is 0.
- R5: A start request is ignored while the block is busy. A start request with N equal to 0 is also ignored: no found pulse, no change of address and no change of busy state.
- R6: The address counter is ADDR_W bits wide, 17 by default. It wraps from its maximum value to zero and keeps going, both during the scan and during playback.
- R7: In playback, a step accepted while data is ready reads the byte at `mem_addr_o` and advances the address by one. A step in the clock right after an accepted step is ignored. Without an accepted step the address holds.
- R8: Message bytes appear on `audio_o` in memory order, one `audio_vld_o` pulse per accepted step, five steps late. Terminator bytes are never emitted.
- R9: The step that delivers the last terminator byte raises `done_o` for one clock in the following clock. In that same clock `busy_o` falls, and `mem_addr_o` points just past the terminator.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (scan rate) |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request, sampled while idle |
| msg_num_i | input | NUM_W | Message number N, counted from 1 |
| step_i | input | 1 | Playback strobe, one byte per accepted step |
| mem_data_i | input | DATA_W | Memory read data, valid one clock after the address |
| mem_addr_o | output | ADDR_W | Memory address |
| busy_o | output | 1 | Scanning or playing |
| found_o | output | 1 | One-clock pulse when the message base is known |
| msg_base_o | output | ADDR_W | First address of the requested message |
| audio_vld_o | output | 1 | Audio byte strobe |
| audio_o | output | DATA_W | Audio byte |
| done_o | output | 1 | One-clock pulse at the end of the message |

## Verification
The step that completes a terminator is also the step on which the hold-back line would emit its oldest byte. End detection and audio emission therefore fall in the same clock, and the terminator bytes must be dropped while `done_o` rises. Every played message ends directly in a terminator, which provokes this case on each run. One message also carries a five-byte 0xAA run inside its data, and another wraps through the top of memory. A scoreboard queue of the expected audio bytes judges the result: it must drain in order, with no surplus emission, by the time `done_o` rises on the expected step. A second collision is a start request or a doubled step that arrives while playback is active; both must leave the address and the found pulse untouched.

// File: rtl/msgloc_pkg.sv
package msgloc_pkg;

   typedef enum logic [1:0] {
      LOC_IDLE = 2'd0,
      LOC_SCAN = 2'd1,
      LOC_PLAY = 2'd2
   } loc_state_e;

endpackage

// File: rtl/msgloc_flag_det.sv
module msgloc_flag_det #(
   parameter int          DATA_W   = 8,
   parameter int          MARK_LEN = 6,
   parameter logic [7:0]  MARK_VAL = 8'hAA
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              byte_vld,
   input  logic [DATA_W-1:0] byte_in,
   output logic              hit
);
   localparam int RUN_W = $clog2(MARK_LEN + 1);
   localparam logic [RUN_W-1:0] RUN_LAST = RUN_W'(MARK_LEN - 1);

   logic [RUN_W-1:0] run_q;
   logic             is_mark;

   initial begin
      assert (MARK_LEN >= 2) else $error("msgloc_flag_det: MARK_LEN must be at least 2");
      assert (DATA_W >= 1 && DATA_W <= 8) else $error("msgloc_flag_det: DATA_W out of range");
   end

   assign is_mark = (byte_in == MARK_VAL[DATA_W-1:0]);
   assign hit     = byte_vld && is_mark && (run_q == RUN_LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              run_q <= '0;
      else if (clr)            run_q <= '0;
      else if (byte_vld) begin
         if (!is_mark || run_q == RUN_LAST) run_q <= '0;
         else                               run_q <= run_q + RUN_W'(1);
      end
   end

   // R2: the run never reaches a full terminator length in state
   p_run_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
      run_q <= RUN_LAST);

   // R2: a non-marker byte clears the run
   p_run_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_vld && !is_mark) |=> (run_q == '0));

endmodule

// File: rtl/msgloc_holdback.sv
module msgloc_holdback #(
   parameter int DATA_W = 8,
   parameter int DEPTH  = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              push,
   input  logic              drop,
   input  logic [DATA_W-1:0] din,
   output logic              out_vld,
   output logic [DATA_W-1:0] out_byte
);
   logic flush;
   logic tail_v;
   logic [DATA_W-1:0] tail_d;

   initial begin
      assert (DEPTH >= 1) else $error("msgloc_holdback: DEPTH must be at least 1");
   end

   assign flush = clr || (push && drop);

   for (genvar g = 0; g < DEPTH; g++) begin : g_stg
      logic              v;
      logic [DATA_W-1:0] d;
      logic              src_v;
      logic [DATA_W-1:0] src_d;
      if (g == 0) begin : g_head
         assign src_v = 1'b1;
         assign src_d = din;
      end else begin : g_link
         assign src_v = g_stg[g-1].v;
         assign src_d = g_stg[g-1].d;
      end
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            v <= 1'b0;
            d <= '0;
         end else if (flush) begin
            v <= 1'b0;
         end else if (push) begin
            v <= src_v;
            d <= src_d;
         end
      end
   end

   assign tail_v = g_stg[DEPTH-1].v;
   assign tail_d = g_stg[DEPTH-1].d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_vld  <= 1'b0;
         out_byte <= '0;
      end else begin
         out_vld <= push && !drop && !clr && tail_v;
         if (push) out_byte <= tail_d;
      end
   end

   // R8: a terminator-completing step never emits a byte
   p_no_emit_on_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (push && drop) |=> !out_vld);

   // R8: an emission is always caused by a step
   p_emit_needs_push_r8: assert property (@(posedge clk) disable iff (!rst_n)
      out_vld |-> $past(push));

endmodule

// File: rtl/msg_locator.sv
module msg_locator
   import msgloc_pkg::*;
#(
   parameter int         ADDR_W   = 17,
   parameter int         DATA_W   = 8,
   parameter int         NUM_W    = 4,
   parameter int         MARK_LEN = 6,
   parameter logic [7:0] MARK_VAL = 8'hAA
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [NUM_W-1:0]  msg_num_i,
   input  logic              step_i,
   input  logic [DATA_W-1:0] mem_data_i,
   output logic [ADDR_W-1:0] mem_addr_o,
   output logic              busy_o,
   output logic              found_o,
   output logic [ADDR_W-1:0] msg_base_o,
   output logic              audio_vld_o,
   output logic [DATA_W-1:0] audio_o,
   output logic              done_o
);
   localparam int HOLD_DEPTH = MARK_LEN - 1;
   localparam logic [ADDR_W-1:0] ADDR_ONE = ADDR_W'(1);
   localparam logic [NUM_W-1:0]  NUM_ONE  = NUM_W'(1);

   loc_state_e        st_q;
   logic [ADDR_W-1:0] addr_q;
   logic [ADDR_W-1:0] base_q;
   logic [NUM_W-1:0]  cnt_q;
   logic [NUM_W-1:0]  target_q;
   logic              rdy_q;
   logic              scan_q;
   logic              found_q;
   logic              done_q;

   logic start_ok;
   logic scan_vld;
   logic take;
   logic det_vld;
   logic hit;
   logic last_mark;

   initial begin
      assert (ADDR_W >= 2) else $error("msg_locator: ADDR_W too small");
      assert (NUM_W >= 1)  else $error("msg_locator: NUM_W too small");
   end

   assign start_ok  = start_i && (st_q == LOC_IDLE) && (msg_num_i != '0);
   assign scan_vld  = (st_q == LOC_SCAN) && scan_q;
   assign take      = (st_q == LOC_PLAY) && step_i && rdy_q;
   assign det_vld   = scan_vld || take;
   assign last_mark = hit && (st_q == LOC_SCAN) && ((cnt_q + NUM_ONE) == target_q);

   msgloc_flag_det #(
      .DATA_W  (DATA_W),
      .MARK_LEN(MARK_LEN),
      .MARK_VAL(MARK_VAL)
   ) det_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (start_ok),
      .byte_vld(det_vld),
      .byte_in (mem_data_i),
      .hit     (hit)
   );

   msgloc_holdback #(
      .DATA_W(DATA_W),
      .DEPTH (HOLD_DEPTH)
   ) hold_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (start_ok),
      .push    (take),
      .drop    (hit),
      .din     (mem_data_i),
      .out_vld (audio_vld_o),
      .out_byte(audio_o)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q     <= LOC_IDLE;
         addr_q   <= '0;
         base_q   <= '0;
         cnt_q    <= '0;
         target_q <= '0;
         rdy_q    <= 1'b0;
         scan_q   <= 1'b0;
         found_q  <= 1'b0;
         done_q   <= 1'b0;
      end else begin
         found_q <= 1'b0;
         done_q  <= 1'b0;
         unique case (st_q)
            LOC_IDLE: begin
               if (start_ok) begin
                  addr_q   <= '0;
                  cnt_q    <= '0;
                  rdy_q    <= 1'b0;
                  scan_q   <= 1'b0;
                  target_q <= msg_num_i - NUM_ONE;
                  if (msg_num_i == NUM_ONE) begin
                     st_q    <= LOC_PLAY;
                     found_q <= 1'b1;
                     base_q  <= '0;
                  end else begin
                     st_q <= LOC_SCAN;
                  end
               end
            end
            LOC_SCAN: begin
               scan_q <= 1'b1;
               if (last_mark) begin
                  st_q    <= LOC_PLAY;
                  found_q <= 1'b1;
                  base_q  <= addr_q;
                  rdy_q   <= 1'b1;
               end else begin
                  addr_q <= addr_q + ADDR_ONE;
                  if (hit) cnt_q <= cnt_q + NUM_ONE;
               end
            end
            LOC_PLAY: begin
               if (take) begin
                  addr_q <= addr_q + ADDR_ONE;
                  rdy_q  <= 1'b0;
                  if (hit) begin
                     done_q <= 1'b1;
                     st_q   <= LOC_IDLE;
                  end
               end else begin
                  rdy_q <= 1'b1;
               end
            end
            default: st_q <= LOC_IDLE;
         endcase
      end
   end

   assign mem_addr_o = addr_q;
   assign msg_base_o = base_q;
   assign busy_o     = (st_q != LOC_IDLE);
   assign found_o    = found_q;
   assign done_o     = done_q;

   // R3, R6: the scan advances one address per clock (wrapping) until the base is found
   p_scan_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == LOC_SCAN) |=> (found_o || mem_addr_o == $past(mem_addr_o) + ADDR_ONE));

   // R3: a found pulse coincides with the start of playback
   p_found_play_r3: assert property (@(posedge clk) disable iff (!rst_n)
      found_o |-> (busy_o && st_q == LOC_PLAY));

   // R7: without an accepted step the playback address holds
   p_play_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == LOC_PLAY && !take) |=> $stable(mem_addr_o));

   // R9: done is a single pulse and the block is idle with it
   p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (!busy_o && !audio_vld_o));

   // R5: a start while busy leaves the address untouched in the scan
   p_busy_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == LOC_SCAN && start_i) |=> !$stable(mem_addr_o) || found_o);

endmodule

// File: tb/msg_locator_tb.sv
`timescale 1ns/1ps
module msg_locator_tb_top;
   localparam int AW  = 10;
   localparam int DW  = 8;
   localparam int NW  = 4;
   localparam int MSZ = 1 << AW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start_i = 1'b0;
   logic [NW-1:0] msg_num_i = '0;
   logic          step_i = 1'b0;
   logic [DW-1:0] mem_data_i;
   logic [AW-1:0] mem_addr_o;
   logic          busy_o, found_o, audio_vld_o, done_o;
   logic [AW-1:0] msg_base_o;
   logic [DW-1:0] audio_o;

   logic [7:0] mem [MSZ];
   logic [7:0] exp_q [$];
   int checks = 0;
   int fails  = 0;
   int cyc    = 0;

   always #2 clk = ~clk;

   msg_locator #(.ADDR_W(AW), .DATA_W(DW), .NUM_W(NW)) dut_i (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .msg_num_i(msg_num_i),
      .step_i(step_i), .mem_data_i(mem_data_i), .mem_addr_o(mem_addr_o),
      .busy_o(busy_o), .found_o(found_o), .msg_base_o(msg_base_o),
      .audio_vld_o(audio_vld_o), .audio_o(audio_o), .done_o(done_o));

   // synchronous memory: data valid one clock after the address
   always_ff @(posedge clk) mem_data_i <= mem[mem_addr_o];

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         checks++;
         fails++;
         $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
         finish_run();
      end
   end

   // scoreboard monitor, R8
   always @(negedge clk) begin
      if (rst_n && audio_vld_o) begin
         if (exp_q.size() == 0) begin
            chk(1'b0, "R8 surplus audio", int'(audio_o), -1);
         end else begin
            automatic logic [7:0] e = exp_q.pop_front();
            chk(audio_o == e, "R8 audio byte", int'(audio_o), int'(e));
         end
      end
   end

   task automatic start_find(input int n, input int exp_base, input int exp_lat, input string tag);
      int lat;
      @(negedge clk);
      start_i   = 1'b1;
      msg_num_i = NW'(n);
      @(negedge clk);
      start_i = 1'b0;
      lat = 1;
      while (!found_o && lat < 5000) begin
         @(negedge clk);
         lat++;
      end
      chk(lat == exp_lat, {tag, " found latency"}, lat, exp_lat);
      chk(int'(msg_base_o) == exp_base, {tag, " base"}, int'(msg_base_o), exp_base);
   endtask

   task automatic play_msg(input int base, input bit dbl, input string tag);
      logic [7:0] tmp [$];
      int a = base;
      int run = 0;
      int n = 0;
      bit early = 0;
      bit dseen = 0;
      forever begin
         automatic logic [7:0] b = mem[a];
         tmp.push_back(b);
         n++;
         a = (a + 1) % MSZ;
         if (b == 8'hAA) begin
            run++;
            if (run == 6) break;
         end else run = 0;
      end
      for (int k = 0; k < 6; k++) void'(tmp.pop_back());
      foreach (tmp[k]) exp_q.push_back(tmp[k]);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         step_i = 1'b1;
         @(negedge clk);
         if (i == n - 1) dseen = done_o;
         else if (done_o) early = 1;
         if (dbl) @(negedge clk);
         step_i = 1'b0;
         @(negedge clk);
      end
      chk(!early, {tag, " R9 early done"}, int'(early), 0);
      chk(dseen, {tag, " R9 done on last marker step"}, int'(dseen), 1);
      chk(!busy_o, {tag, " R9 idle after done"}, int'(busy_o), 0);
      chk(int'(mem_addr_o) == a, {tag, " R7 address after message"}, int'(mem_addr_o), a);
      chk(exp_q.size() == 0, {tag, " R8 all audio drained"}, exp_q.size(), 0);
   endtask

   initial begin
      for (int i = 0; i < MSZ; i++) begin
         automatic logic [7:0] p = 8'((i * 37 + 11) & 8'hFF);
         mem[i] = (p == 8'hAA) ? 8'h5A : p;
      end
      for (int i = 10; i < 15; i++) mem[i] = 8'hAA;   // five-byte run inside message 1
      for (int i = 20; i < 26; i++) mem[i] = 8'hAA;   // terminator 1
      for (int i = 56; i < 62; i++) mem[i] = 8'hAA;   // terminator 2
      for (int i = 72; i < 78; i++) mem[i] = 8'hAA;   // terminator 3

      repeat (3) @(negedge clk);
      chk(!busy_o && !found_o && !done_o && !audio_vld_o, "R1 reset outputs", int'(busy_o), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(mem_addr_o == '0 && !busy_o, "R1 reset address", int'(mem_addr_o), 0);

      // R5: N of zero is ignored
      @(negedge clk);
      start_i = 1'b1;
      msg_num_i = '0;
      @(negedge clk);
      start_i = 1'b0;
      chk(!busy_o && !found_o, "R5 zero request ignored", int'(busy_o), 0);

      // R4, R2, R8, R9: message 1 without scan, five-byte run played as audio
      start_find(1, 0, 1, "R4 msg1");
      play_msg(0, 1'b0, "msg1");

      // R3, R7: message 2 with doubled steps and a start while busy (R5)
      start_find(2, 26, 28, "R3 msg2");
      @(negedge clk);
      start_i = 1'b1;
      msg_num_i = NW'(1);
      @(negedge clk);
      start_i = 1'b0;
      chk(!found_o && int'(mem_addr_o) == 26 && busy_o, "R5 start while busy ignored", int'(mem_addr_o), 26);
      play_msg(26, 1'b1, "R7 msg2 doubled steps");

      // R3: message 3
      start_find(3, 62, 64, "R3 msg3");
      play_msg(62, 1'b0, "msg3");

      // R6: message 4 plays through the top of memory and wraps
      start_find(4, 78, 80, "R3 msg4");
      play_msg(78, 1'b0, "R6 msg4 wrap");

      // R6: scan wraps; the fourth terminator is terminator 1 seen again
      start_find(5, 26, MSZ + 25 + 3, "R6 scan wrap");
      play_msg(26, 1'b0, "R6 msg after wrap");

      repeat (4) @(negedge clk);
      finish_run();
   end
endmodule